// File: doc/BRIEF.md
# Disk attachment host register interface

This block is the host-facing register set of a fixed-disk attachment. The host starts work by writing an attention byte, which holds a 3-bit device number and an attention code. It then pushes command words through a one-word command port. The attachment assembles the complete command and hands it to a backend over a valid/ready stream. It then waits for the backend to report a result on a second valid/ready stream. Each result raises an interrupt that carries an interrupt ID and the device number, and any status block is presented to the host one word at a time.

Six registers sit behind a small address decoder:

| Address | Name | Access | Use |
|---|---|---|---|
| 0 | status | read | state flags |
| 1 | control | read/write | interrupt enable, DMA enable, reset |
| 2 | attention | write | attention byte |
| 3 | interrupt ID | read | read clears the interrupt |
| 4 | command word | write | command port |
| 5 | status word | read | read pops the word |

Read data is combinational from the address. A read has side effects only at addresses 3 and 5, in the clock edge where `reg_rd` is high.

The command stream holds `cmd_valid` and the whole command block steady until the backend asserts `cmd_ready`. The response stream is accepted only when `rsp_ready` is high, and `rsp_ready` does not depend on `rsp_valid`. The first response beat after a command carries the interrupt ID and the first status word. Later beats carry only further status words, and their `rsp_id` is ignored. The backend stalls simply by keeping `rsp_valid` low. Disk mechanics, error correction and the DMA data path stay outside the block.

Top module: `disk_attach_regs`

## Requirements
- R1: After reset, and after a control write with bit 7 set, status and control read 0, `irq` and `dma_en` are 0, `cmd_valid` is 0 and `rsp_ready` is 0.
- R2: The status register bits are: busy (bit 0), interrupt pending (bit 1), command in progress (bit 2), command word full (bit 3) and status word full (bit 4). Busy rises when an attention is accepted and stays high until the interrupt for that work is raised.
- R3: The attention byte holds the device in bits 7:5 and the code in bits 4:0. Codes 0x01, 0x02 and 0x04 are command request, end of interrupt and reset attachment. An attention other than end of interrupt is ignored while busy. End of interrupt is accepted at any time.
- R4: A command-word write sets command word full, and the attachment clears it on the next clock when it takes the word. Command-word writes made while no command request is open are ignored.
- R5: Bit 14 of the first command word selects the command length: 0 means two words and 1 means four words. Once the last word is taken, `cmd_valid` rises with `cmd_code` (word 0 bits 4:0), `cmd_dev` (word 0 bits 7:5), `cmd_nwords` and `cmd_block` (word i in bits 16i+15:16i, unused words 0). These outputs hold until `cmd_ready`. Command in progress stays high from then until the final interrupt.
- R6: The interrupt ID register reads {device, 0, id[3:0]}. A read clears interrupt pending. `irq` equals pending AND control bit 0.
- R7: The high byte of the first status word gives the block length in words. The first word is shown with status word full set. Each later word is fetched from the response stream only after the host has read the previous one.
- R8: After any interrupt other than data-transfer-ready (ID 0xB) or attention error (ID 0xF), no further interrupt is raised until an end-of-interrupt attention.
- R9: A data-transfer-ready response raises ID 0xB and keeps busy and command in progress high. The next response is accepted only once control bit 1 (DMA enable, driven on `dma_en`) is set.
- R10: A reset-attachment attention raises ID 0xA with no status block.
- R11: An undefined attention code raises ID 0xF with no status block, and no end of interrupt is needed after it.
- R12: Backend IDs 0, 2 and 4 are reserved. They are reported as 0xC, so a raised interrupt never shows a reserved ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_addr | input | 3 | register address |
| reg_wr | input | 1 | register write strobe |
| reg_rd | input | 1 | register read strobe (side effects at addresses 3 and 5) |
| reg_wdata | input | 16 | write data |
| reg_rdata | output | 16 | read data for reg_addr |
| irq | output | 1 | interrupt request |
| dma_en | output | 1 | DMA enable from control bit 1 |
| cmd_valid | output | 1 | command stream valid |
| cmd_ready | input | 1 | command stream ready |
| cmd_code | output | 5 | command code |
| cmd_dev | output | 3 | device from command word 0 |
| cmd_nwords | output | 3 | command length in words |
| cmd_block | output | 64 | packed command words |
| rsp_valid | input | 1 | response stream valid |
| rsp_ready | output | 1 | response stream ready |
| rsp_id | input | 4 | interrupt ID on the first response beat |
| rsp_word | input | 16 | status word |

## Verification
The bench builds the block with the default parameters: 16-bit words, a short command of two words and a long command of four words, and an 8-bit length field. With these values both command lengths can be reached, including holding a four-word command against a stalled `cmd_ready`. A three-word status block exercises the fetch-after-read sequence. The defaults also cover the interplay of end of interrupt, data-transfer-ready gating on DMA enable, reserved-ID remapping, attention ignored while busy, and a mid-command control reset.

// File: rtl/disk_attach_pkg.sv
`timescale 1ns/1ps
package disk_attach_pkg;
  localparam int WORD_W = 16;
  localparam int DEV_W  = 3;
  localparam int ID_W   = 4;
  localparam int CODE_W = 5;

  // register addresses
  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd1;
  localparam logic [2:0] A_ATTN = 3'd2;
  localparam logic [2:0] A_ISR  = 3'd3;
  localparam logic [2:0] A_CMD  = 3'd4;
  localparam logic [2:0] A_STS  = 3'd5;

  // attention codes
  localparam logic [CODE_W-1:0] ATTN_CMD = 5'h01;
  localparam logic [CODE_W-1:0] ATTN_EOI = 5'h02;
  localparam logic [CODE_W-1:0] ATTN_RST = 5'h04;

  // interrupt IDs produced by the attachment itself
  localparam logic [ID_W-1:0] ID_RST_DONE = 4'hA;
  localparam logic [ID_W-1:0] ID_XFER_RDY = 4'hB;
  localparam logic [ID_W-1:0] ID_FAIL     = 4'hC;
  localparam logic [ID_W-1:0] ID_ATTN_ERR = 4'hF;

  typedef enum logic [1:0] {SQ_IDLE, SQ_COLLECT, SQ_EXEC, SQ_RAISE} seq_state_e;

  function automatic logic id_reserved(input logic [ID_W-1:0] id);
    return (id == 4'h0) || (id == 4'h2) || (id == 4'h4);
  endfunction
endpackage

// File: rtl/disk_cmd_collector.sv
`timescale 1ns/1ps
module disk_cmd_collector #(
  parameter int WORD_W      = 16,
  parameter int SHORT_WORDS = 2,
  parameter int LONG_WORDS  = 4,
  parameter int LEN_BIT     = 14,
  localparam int CNT_W      = $clog2(LONG_WORDS + 1),
  localparam int IDX_W      = $clog2(LONG_WORDS),
  localparam int BLOCK_W    = WORD_W * LONG_WORDS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               arm,
  input  logic               wr_en,
  input  logic [WORD_W-1:0]  wr_word,
  output logic               full,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [BLOCK_W-1:0] cmd_block,
  output logic [CNT_W-1:0]   cmd_nwords
);
  logic [WORD_W-1:0] slot_q [LONG_WORDS];
  logic [WORD_W-1:0] hold_q;
  logic [CNT_W-1:0]  idx_q, need_q, need_now, idx_nxt;
  logic              open_q, full_q, valid_q;

  assign need_now = (idx_q == '0) ? (hold_q[LEN_BIT] ? CNT_W'(LONG_WORDS) : CNT_W'(SHORT_WORDS))
                                  : need_q;
  assign idx_nxt  = idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; full_q <= 1'b0; valid_q <= 1'b0;
      hold_q <= '0; idx_q <= '0; need_q <= '0;
      for (int i = 0; i < LONG_WORDS; i++) slot_q[i] <= '0;
    end else if (clr) begin
      open_q <= 1'b0; full_q <= 1'b0; valid_q <= 1'b0;
      idx_q <= '0; need_q <= '0;
    end else begin
      if (arm) begin
        open_q <= 1'b1;
        idx_q  <= '0;
        for (int i = 0; i < LONG_WORDS; i++) slot_q[i] <= '0;
      end
      if (wr_en && open_q && !full_q) begin
        full_q <= 1'b1;
        hold_q <= wr_word;
      end
      if (full_q) begin
        full_q <= 1'b0;
        slot_q[idx_q[IDX_W-1:0]] <= hold_q;
        need_q <= need_now;
        if (idx_nxt == need_now) begin
          open_q  <= 1'b0;
          valid_q <= 1'b1;
        end else begin
          idx_q <= idx_nxt;
        end
      end
      if (valid_q && cmd_ready) valid_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < LONG_WORDS; g++) begin : g_pack
    assign cmd_block[g*WORD_W +: WORD_W] = slot_q[g];
  end

  assign full       = full_q;
  assign cmd_valid  = valid_q;
  assign cmd_nwords = need_q;

  // R5: a stalled command keeps its contents
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_block) && $stable(cmd_nwords)));

  // R4: a taken word leaves the port free on the next clock
  p_word_taken_r4: assert property (@(posedge clk) disable iff (!rst_n || clr)
    full |=> !full);
endmodule

// File: rtl/disk_sts_presenter.sv
`timescale 1ns/1ps
module disk_sts_presenter #(
  parameter int WORD_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              pop,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_word,
  output logic              rsp_ready,
  output logic              full,
  output logic [WORD_W-1:0] word,
  output logic              busy
);
  logic [LEN_W-1:0]  len, rem_q;
  logic [WORD_W-1:0] word_q;
  logic              full_q;

  assign len = load_word[WORD_W-1 -: LEN_W];
  assign rsp_ready = !full_q && (rem_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0; rem_q <= '0; word_q <= '0;
    end else if (clr) begin
      full_q <= 1'b0; rem_q <= '0;
    end else begin
      if (pop && full_q) full_q <= 1'b0;
      if (load) begin
        word_q <= load_word;
        full_q <= 1'b1;
        rem_q  <= (len > LEN_W'(1)) ? len - 1'b1 : '0;
      end else if (rsp_valid && rsp_ready) begin
        word_q <= rsp_word;
        full_q <= 1'b1;
        rem_q  <= rem_q - 1'b1;
      end
    end
  end

  assign full = full_q;
  assign word = word_q;
  assign busy = full_q || (rem_q != '0);

  // R7: a host read empties the status word
  p_pop_empties_r7: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (pop && full && !load) |=> !full);
endmodule

// File: rtl/disk_attn_seq.sv
`timescale 1ns/1ps
module disk_attn_seq
  import disk_attach_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            attn_wr,
  input  logic [7:0]      attn_data,
  input  logic            isr_rd,
  input  logic            dma_en,
  input  logic            pres_busy,
  input  logic            cmd_valid,
  input  logic            cmd_sent,
  input  logic            rsp_valid,
  input  logic [ID_W-1:0] rsp_id,
  output logic            rsp_ready,
  output logic            arm,
  output logic            load,
  output logic            busy,
  output logic            pending,
  output logic            in_prog,
  output logic [7:0]      isr_data
);
  seq_state_e        state_q;
  logic [DEV_W-1:0]  dev_q;
  logic [ID_W-1:0]   id_q, raise_id_q, mapped_id;
  logic              pending_q, eoi_wait_q, xfer_wait_q, gate, take;
  logic [CODE_W-1:0] code;

  assign code      = attn_data[CODE_W-1:0];
  assign gate      = !pending_q && !eoi_wait_q;
  assign rsp_ready = (state_q == SQ_EXEC) && gate && !pres_busy && (!xfer_wait_q || dma_en);
  assign take      = rsp_valid && rsp_ready;
  assign mapped_id = id_reserved(rsp_id) ? ID_FAIL : rsp_id;
  assign load      = take && (mapped_id != ID_XFER_RDY);
  assign arm       = attn_wr && (state_q == SQ_IDLE) && (code == ATTN_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE; dev_q <= '0; id_q <= '0; raise_id_q <= '0;
      pending_q <= 1'b0; eoi_wait_q <= 1'b0; xfer_wait_q <= 1'b0;
    end else if (clr) begin
      state_q <= SQ_IDLE; dev_q <= '0; id_q <= '0;
      pending_q <= 1'b0; eoi_wait_q <= 1'b0; xfer_wait_q <= 1'b0;
    end else begin
      if (isr_rd && pending_q) pending_q <= 1'b0;
      if (attn_wr && code == ATTN_EOI) eoi_wait_q <= 1'b0;
      unique case (state_q)
        SQ_IDLE: if (attn_wr && code != ATTN_EOI) begin
          dev_q <= attn_data[7:5];
          if (code == ATTN_CMD) state_q <= SQ_COLLECT;
          else begin
            raise_id_q <= (code == ATTN_RST) ? ID_RST_DONE : ID_ATTN_ERR;
            state_q    <= SQ_RAISE;
          end
        end
        SQ_COLLECT: if (cmd_sent) state_q <= SQ_EXEC;
        SQ_EXEC: if (take) begin
          pending_q <= 1'b1;
          id_q      <= mapped_id;
          if (mapped_id == ID_XFER_RDY) xfer_wait_q <= 1'b1;
          else begin
            xfer_wait_q <= 1'b0;
            eoi_wait_q  <= 1'b1;
            state_q     <= SQ_IDLE;
          end
        end
        SQ_RAISE: if (gate) begin
          pending_q  <= 1'b1;
          id_q       <= raise_id_q;
          eoi_wait_q <= (raise_id_q != ID_ATTN_ERR);
          state_q    <= SQ_IDLE;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign pending  = pending_q;
  assign in_prog  = (state_q == SQ_EXEC) || ((state_q == SQ_COLLECT) && cmd_valid);
  assign isr_data = {dev_q, 1'b0, id_q};

  // R12: a raised interrupt never carries a reserved ID
  p_no_reserved_id_r12: assert property (@(posedge clk) disable iff (!rst_n || clr)
    pending |-> !id_reserved(isr_data[ID_W-1:0]));

  // R8: no interrupt rises while an end of interrupt is owed
  p_eoi_gate_r8: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(pending) |-> !$past(eoi_wait_q));

  // R2: busy only drops together with a raised interrupt
  p_busy_until_irq_r2: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ($fell(busy) && !$past(clr)) |-> pending);
endmodule

// File: rtl/disk_attach_regs.sv
`timescale 1ns/1ps
module disk_attach_regs
  import disk_attach_pkg::*;
#(
  parameter int SHORT_WORDS = 2,
  parameter int LONG_WORDS  = 4,
  parameter int LEN_W       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq,
  output logic        dma_en,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [4:0]  cmd_code,
  output logic [2:0]  cmd_dev,
  output logic [2:0]  cmd_nwords,
  output logic [63:0] cmd_block,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [3:0]  rsp_id,
  input  logic [15:0] rsp_word
);
  logic        clr, ctrl_wr, attn_wr, cmd_wr, isr_rd, sts_pop;
  logic        ien_q, dma_q;
  logic        cmd_full, cmd_sent, arm, load;
  logic        busy, pending, in_prog, sts_full, pres_busy;
  logic        seq_ready, pres_ready;
  logic [7:0]  isr_data;
  logic [15:0] sts_word;
  logic        wdata_unused;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign clr     = ctrl_wr && reg_wdata[7];
  assign attn_wr = reg_wr && (reg_addr == A_ATTN);
  assign cmd_wr  = reg_wr && (reg_addr == A_CMD);
  assign isr_rd  = reg_rd && (reg_addr == A_ISR);
  assign sts_pop = reg_rd && (reg_addr == A_STS);
  assign wdata_unused = ^{reg_wdata[15:8], reg_wdata[6:2]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= 1'b0; dma_q <= 1'b0;
    end else if (clr) begin
      ien_q <= 1'b0; dma_q <= 1'b0;
    end else if (ctrl_wr) begin
      ien_q <= reg_wdata[0];
      dma_q <= reg_wdata[1];
    end
  end

  disk_cmd_collector #(
    .WORD_W(WORD_W), .SHORT_WORDS(SHORT_WORDS), .LONG_WORDS(LONG_WORDS), .LEN_BIT(14)
  ) u_collect (
    .clk(clk), .rst_n(rst_n), .clr(clr), .arm(arm), .wr_en(cmd_wr), .wr_word(reg_wdata),
    .full(cmd_full), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_block(cmd_block), .cmd_nwords(cmd_nwords)
  );

  assign cmd_sent = cmd_valid && cmd_ready;
  assign cmd_code = cmd_block[4:0];
  assign cmd_dev  = cmd_block[7:5];

  disk_attn_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr(clr), .attn_wr(attn_wr), .attn_data(reg_wdata[7:0]),
    .isr_rd(isr_rd), .dma_en(dma_q), .pres_busy(pres_busy), .cmd_valid(cmd_valid),
    .cmd_sent(cmd_sent), .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_ready(seq_ready),
    .arm(arm), .load(load), .busy(busy), .pending(pending), .in_prog(in_prog),
    .isr_data(isr_data)
  );

  disk_sts_presenter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_sts (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_word(rsp_word), .pop(sts_pop),
    .rsp_valid(rsp_valid), .rsp_word(rsp_word), .rsp_ready(pres_ready),
    .full(sts_full), .word(sts_word), .busy(pres_busy)
  );

  assign rsp_ready = seq_ready || pres_ready;
  assign irq       = pending && ien_q;
  assign dma_en    = dma_q;

  always_comb begin
    unique case (reg_addr)
      A_STAT:  reg_rdata = {11'd0, sts_full, cmd_full, in_prog, pending, busy};
      A_CTRL:  reg_rdata = {14'd0, dma_q, ien_q};
      A_ISR:   reg_rdata = {8'd0, isr_data};
      A_STS:   reg_rdata = sts_word;
      default: reg_rdata = 16'd0;
    endcase
  end

  // R7: only one side of the block owns the response stream at a time
  p_rsp_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_ready && pres_ready));

  // R6: an interrupt ID read drops the request line
  p_isr_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (isr_rd && pending) |=> !irq);
endmodule

// File: tb/test_disk_attach_regs.sv
`timescale 1ns/1ps
module test_disk_attach_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        irq, dma_en, cmd_valid, rsp_ready;
  logic        cmd_ready = 1'b1, rsp_valid = 1'b0;
  logic [4:0]  cmd_code;
  logic [2:0]  cmd_dev, cmd_nwords;
  logic [63:0] cmd_block;
  logic [3:0]  rsp_id = '0;
  logic [15:0] rsp_word = '0;

  int n_chk = 0, n_bad = 0;
  logic [63:0] got_block;
  logic [4:0]  got_code;
  logic [2:0]  got_dev, got_n;

  always #2 clk = ~clk;

  disk_attach_regs i_disk_attach_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .dma_en(dma_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_dev(cmd_dev),
    .cmd_nwords(cmd_nwords), .cmd_block(cmd_block), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_word(rsp_word)
  );

  // backend monitor: record the command at its handshake
  always @(posedge clk) if (cmd_valid && cmd_ready) begin
    got_block = cmd_block; got_code = cmd_code; got_dev = cmd_dev; got_n = cmd_nwords;
  end

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    report();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] d;
    rd(a, d);
    chk(tag, {48'd0, d}, {48'd0, exp});
  endtask

  task automatic send_rsp(input logic [3:0] id, input logic [15:0] w);
    @(negedge clk); rsp_valid = 1'b1; rsp_id = id; rsp_word = w;
    while (!rsp_ready) @(negedge clk);
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 status after reset", 3'd0, 16'h0000);
    rd_chk("R1 control after reset", 3'd1, 16'h0000);
    chk("R1 irq/dma/cmd_valid/rsp_ready", {irq, dma_en, cmd_valid, rsp_ready}, 4'b0000);
  endtask

  task automatic t_stray_word();
    wr(3'd4, 16'h1234);
    reg_addr = 3'd0; #1;
    chk("R4 stray command word ignored", reg_rdata, 16'h0000);
  endtask

  task automatic t_short_cmd();
    wr(3'd1, 16'h0001);
    wr(3'd2, 16'h0021);
    rd_chk("R2 busy after command request", 3'd0, 16'h0001);
    wr(3'd4, 16'h0025);
    reg_addr = 3'd0; #1;
    chk("R4 command word full set", reg_rdata, 16'h0009);
    rd_chk("R4 command word full cleared", 3'd0, 16'h0001);
    wr(3'd4, 16'hBEEF);
    idle(2);
    chk("R5 short command block", got_block, 64'h0000_0000_BEEF_0025);
    chk("R5 short code/dev/len", {got_code, got_dev, got_n}, {5'd5, 3'd1, 3'd2});
    rd_chk("R5 in progress while executing", 3'd0, 16'h0005);
    send_rsp(4'h1, 16'h0301);
    rd_chk("R2 busy drops with interrupt", 3'd0, 16'h0012);
    chk("R6 irq raised when enabled", irq, 1'b1);
    reg_addr = 3'd5; #1;
    chk("R7 no fetch before status read", rsp_ready, 1'b0);
    rd_chk("R6 interrupt ID format", 3'd3, 16'h0021);
    chk("R6 irq cleared by read", irq, 1'b0);
    rd_chk("R7 first status word", 3'd5, 16'h0301);
    send_rsp(4'h0, 16'h1111);
    rd_chk("R7 second word shown", 3'd0, 16'h0010);
    rd_chk("R7 second status word", 3'd5, 16'h1111);
    send_rsp(4'h0, 16'h2222);
    rd_chk("R7 third status word", 3'd5, 16'h2222);
    rd_chk("R7 block drained", 3'd0, 16'h0000);
    chk("R7 no fetch past length", rsp_ready, 1'b0);
    wr(3'd2, 16'h0022);
  endtask

  task automatic t_long_cmd_and_eoi();
    wr(3'd2, 16'h0001);
    wr(3'd4, 16'h4003);
    wr(3'd4, 16'h0001);
    wr(3'd4, 16'h0002);
    idle(2);
    chk("R5 long command not yet issued", cmd_valid, 1'b0);
    cmd_ready = 1'b0;
    wr(3'd4, 16'h0003);
    idle(3);
    chk("R5 stalled command held", {cmd_valid, cmd_block}, {1'b1, 64'h0003_0002_0001_4003});
    cmd_ready = 1'b1;
    idle(2);
    chk("R5 long code/dev/len", {got_code, got_dev, got_n}, {5'd3, 3'd0, 3'd4});
    send_rsp(4'h5, 16'h0100);
    rd_chk("R6 long command completion ID", 3'd3, 16'h0005);
    rd_chk("R7 single-word block", 3'd5, 16'h0100);
    wr(3'd2, 16'h0040);
    idle(4);
    rd_chk("R8 interrupt held until end of interrupt", 3'd0, 16'h0001);
    wr(3'd2, 16'h0002);
    rd_chk("R8 interrupt raised after end of interrupt", 3'd0, 16'h0002);
    rd_chk("R11 attention error ID", 3'd3, 16'h004F);
    wr(3'd2, 16'h0060);
    idle(2);
    rd_chk("R11 no end of interrupt needed", 3'd3, 16'h006F);
  endtask

  task automatic t_reset_attn();
    wr(3'd2, 16'h0004);
    idle(2);
    rd_chk("R10 reset attention raises, no status", 3'd0, 16'h0002);
    rd_chk("R10 reset done ID", 3'd3, 16'h000A);
    wr(3'd2, 16'h0002);
  endtask

  task automatic t_xfer_ready();
    wr(3'd2, 16'h0021);
    wr(3'd4, 16'h0021);
    wr(3'd4, 16'h0010);
    idle(2);
    send_rsp(4'hB, 16'h0000);
    rd_chk("R9 busy and in progress kept", 3'd0, 16'h0007);
    rd_chk("R9 transfer ready ID", 3'd3, 16'h002B);
    @(negedge clk); rsp_valid = 1'b1; rsp_id = 4'h1; rsp_word = 16'h0000;
    #1 chk("R9 response blocked without DMA enable", rsp_ready, 1'b0);
    idle(3);
    chk("R9 still blocked", rsp_ready, 1'b0);
    wr(3'd1, 16'h0003);
    chk("R9 dma_en driven", dma_en, 1'b1);
    while (!rsp_ready) @(negedge clk);
    @(negedge clk); rsp_valid = 1'b0;
    rd_chk("R9 final completion raised", 3'd0, 16'h0012);
    rd_chk("R9 final ID", 3'd3, 16'h0021);
    rd_chk("R7 zero-length block word", 3'd5, 16'h0000);
    wr(3'd2, 16'h0022);
    wr(3'd1, 16'h0001);
  endtask

  task automatic t_reserved_id();
    wr(3'd2, 16'h0021);
    wr(3'd4, 16'h0021);
    wr(3'd4, 16'h0000);
    idle(2);
    send_rsp(4'h2, 16'h0100);
    rd_chk("R12 reserved ID remapped", 3'd3, 16'h002C);
    rd_chk("R12 status word", 3'd5, 16'h0100);
    wr(3'd2, 16'h0022);
  endtask

  task automatic t_busy_ignores();
    wr(3'd2, 16'h0021);
    wr(3'd4, 16'h0021);
    wr(3'd4, 16'h0000);
    idle(2);
    wr(3'd2, 16'h0004);
    rd_chk("R3 attention while busy ignored", 3'd0, 16'h0005);
    send_rsp(4'h1, 16'h0100);
    rd_chk("R3 completion not replaced", 3'd3, 16'h0021);
    rd_chk("R3 status word", 3'd5, 16'h0100);
    wr(3'd2, 16'h0022);
    idle(4);
    rd_chk("R3 no stale interrupt", 3'd0, 16'h0000);
  endtask

  task automatic t_irq_mask();
    wr(3'd1, 16'h0000);
    wr(3'd2, 16'h0000);
    idle(2);
    chk("R6 irq masked", {irq, reg_rdata[1]}, 2'b00);
    rd_chk("R6 pending while masked", 3'd0, 16'h0002);
    wr(3'd1, 16'h0001);
    chk("R6 irq after enable", irq, 1'b1);
    rd_chk("R11 undefined code ID", 3'd3, 16'h000F);
    chk("R6 irq low after read", irq, 1'b0);
  endtask

  task automatic t_soft_reset();
    wr(3'd2, 16'h0021);
    wr(3'd4, 16'h4000);
    wr(3'd1, 16'h0083);
    rd_chk("R1 status after control reset", 3'd0, 16'h0000);
    rd_chk("R1 control after control reset", 3'd1, 16'h0000);
    wr(3'd4, 16'h0001);
    reg_addr = 3'd0; #1;
    chk("R1 collection abandoned", reg_rdata, 16'h0000);
    chk("R1 outputs after control reset", {irq, dma_en, cmd_valid}, 3'b000);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_stray_word();
    t_short_cmd();
    t_long_cmd_and_eoi();
    t_reset_attn();
    t_xfer_ready();
    t_reserved_id();
    t_busy_ignores();
    t_irq_mask();
    t_soft_reset();
    idle(2);
    report();
  end
endmodule